// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives three half-bridge phases from a single edge-aligned up-counter that advances once per clock. Each phase forms a reference waveform, either by comparing the counter with its own compare value or by a forced or frozen level chosen per channel. From that reference it produces a main gate signal and a complementary gate signal. When both gates of a pair are enabled, a fixed dead interval separates the turn-off of one gate from the turn-on of the other.

The period and the three compare values are double-buffered. Values presented at the inputs are copied into the working registers only at the counter wrap, and a one-cycle update pulse marks each wrap. Mode and enable inputs act at once. A master output enable forces all six gates to their inactive level (low) within one clock. After reset the working period is 2250 cycles and every working compare value is 100.

Top module: `pwm3_gen`

## Requirements
- R1: The counter runs 0 to P-1 and wraps, where P is the working period (default 2250). `upd` is high for exactly one cycle, the first cycle after each wrap, so consecutive pulses are P cycles apart. The first pulse after reset comes 2250 cycles after reset is released.
- R2: A new `period_in` value takes effect only at a wrap. The period that is running when the value is written keeps its old length.
- R3: A new compare value on `cmp_in` (channel i in bits [16*i+15:16*i]) takes effect only at a wrap. A value that is present in the last cycle of a period governs the very next period.
- R4: In mode 2'b00 (PWM) the channel reference is high while the counter is below the working compare value. With only the main output enabled, the main output is high for cmp cycles in each period.
- R5: Mode 2'b01 forces the reference high and mode 2'b10 forces it low. `mode_in` holds channel i in bits [2*i+1:2*i].
- R6: Mode 2'b11 (frozen) holds the reference at the value it had when the mode was entered.
- R7: When both outputs of a pair are enabled, each turn-on is delayed by 10 cycles after the reference edge, and the two outputs are never high together. In PWM mode the main output is high for cmp-10 cycles per period and the complementary output for max(P-cmp-10, 0) cycles.
- R8: When only one output of a pair is enabled, it follows the reference with no dead time. With only the complementary output enabled, it is high for P-cmp cycles per period.
- R9: A disabled output (`en_main` or `en_comp` bit i = 0) is held low at all times.
- R10: When `out_en` is low, all six outputs are low from the next clock on.
- R11: After reset all six outputs and `upd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_in | input | 16 | Period to load at the next wrap (values below 2 are treated as 2) |
| cmp_in | input | 48 | Compare values, 16 bits per channel, to load at the next wrap |
| mode_in | input | 6 | Channel modes, 2 bits per channel: 00 PWM, 01 high, 10 low, 11 frozen |
| en_main | input | 3 | Per-channel enable for the main outputs |
| en_comp | input | 3 | Per-channel enable for the complementary outputs |
| out_en | input | 1 | Master output enable |
| pwm_main | output | 3 | Main gate outputs, active high |
| pwm_comp | output | 3 | Complementary gate outputs, active high |
| upd | output | 1 | One-cycle pulse in the first cycle after each wrap |

## Verification
The interesting collision is a write to the compare input that lands in the same cycle as the wrap. The shadow load and the counter reset then happen on one edge, and the new value must govern the period that is just starting. The bench times a compare change into the final cycle of a period, counted from the previous update pulse, and expects the width of the following window to equal the new value. A separate write in mid-period is expected to leave the remainder of that period untouched.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  typedef enum logic [1:0] {
    MODE_PWM  = 2'b00,
    MODE_HI   = 2'b01,
    MODE_LO   = 2'b10,
    MODE_HOLD = 2'b11
  } chan_mode_e;
endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DEF_PERIOD = 2250
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             upd_o
);
  localparam logic [CNT_W-1:0] MIN_P   = CNT_W'(2);
  localparam logic [CNT_W-1:0] RESET_P = CNT_W'(DEF_PERIOD);

  logic [CNT_W-1:0] per_act;

  // wrap happens on the edge that ends the last count of the period
  assign wrap_o = (cnt_o == per_act - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o   <= '0;
      per_act <= RESET_P;
      upd_o   <= 1'b0;
    end else if (wrap_o) begin
      cnt_o   <= '0;
      per_act <= (period_in < MIN_P) ? MIN_P : period_in;
      upd_o   <= 1'b1;
    end else begin
      cnt_o   <= cnt_o + CNT_W'(1);
      upd_o   <= 1'b0;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_o < per_act) else $error("counter beyond period"); // R1
  AST_UPD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> (cnt_o == '0)) else $error("update pulse off zero"); // R1
  AST_PERIOD_PRELOAD: assert property (@(posedge clk) disable iff (rst)
    !$stable(per_act) |-> upd_o) else $error("period changed mid-period"); // R2
endmodule

// File: rtl/pwm3_refgen.sv
module pwm3_refgen
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned DEF_CMP = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cmp_in,
  input  chan_mode_e       mode_i,
  output logic             ref_o
);
  localparam logic [CNT_W-1:0] RESET_CMP = CNT_W'(DEF_CMP);

  logic [CNT_W-1:0] cmp_act;
  logic             ref_n;

  always_ff @(posedge clk) begin
    if (rst)         cmp_act <= RESET_CMP;
    else if (wrap_i) cmp_act <= cmp_in;
  end

  always_comb begin
    unique case (mode_i)
      MODE_PWM: ref_n = (cnt_i < cmp_act);
      MODE_HI:  ref_n = 1'b1;
      MODE_LO:  ref_n = 1'b0;
      default:  ref_n = ref_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ref_o <= 1'b0;
    else     ref_o <= ref_n;
  end

  AST_CMP_PRELOAD: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmp_act) |-> $past(wrap_i)) else $error("compare changed off wrap"); // R3
  AST_FORCE_HI: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_HI) |=> ref_o) else $error("force high not applied"); // R5
  AST_FORCE_LO: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_LO) |=> !ref_o) else $error("force low not applied"); // R5
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_HOLD) |=> $stable(ref_o)) else $error("frozen reference moved"); // R6
endmodule

// File: rtl/pwm3_deadtime.sv
module pwm3_deadtime #(
  parameter int unsigned DT_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  input  logic en_m,
  input  logic en_c,
  input  logic moe,
  output logic out_m,
  output logic out_c
);
  localparam int unsigned DT_W = (DT_CYC < 2) ? 1 : $clog2(DT_CYC + 1);
  localparam logic [DT_W-1:0] DT_LOAD = DT_W'(DT_CYC - 1);

  logic            ref_d;
  logic [DT_W-1:0] dt_cnt;
  logic            hold;

  // dead interval runs from the reference edge for DT_CYC cycles
  assign hold = (ref_i != ref_d) || (dt_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_d  <= 1'b0;
      dt_cnt <= '0;
      out_m  <= 1'b0;
      out_c  <= 1'b0;
    end else begin
      ref_d <= ref_i;
      if (ref_i != ref_d)    dt_cnt <= DT_LOAD;
      else if (dt_cnt != '0) dt_cnt <= dt_cnt - DT_W'(1);
      // a lone enabled output bypasses the dead interval
      out_m <= moe & en_m &  ref_i & (~hold | ~en_c);
      out_c <= moe & en_c & ~ref_i & (~hold | ~en_m);
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(out_m && out_c)) else $error("pair active together"); // R7
  AST_MOE_OFF: assert property (@(posedge clk) disable iff (rst)
    !moe |=> (!out_m && !out_c)) else $error("output active with master off"); // R10
  AST_DIS_MAIN: assert property (@(posedge clk) disable iff (rst)
    !en_m |=> !out_m) else $error("disabled main output active"); // R9
  AST_DIS_COMP: assert property (@(posedge clk) disable iff (rst)
    !en_c |=> !out_c) else $error("disabled complementary output active"); // R9
endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
  import pwm3_pkg::*;
#(
  parameter int unsigned NCH        = 3,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DEF_PERIOD = 2250,
  parameter int unsigned DEF_CMP    = 100,
  parameter int unsigned DT_CYC     = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     period_in,
  input  logic [NCH*CNT_W-1:0] cmp_in,
  input  logic [2*NCH-1:0]     mode_in,
  input  logic [NCH-1:0]       en_main,
  input  logic [NCH-1:0]       en_comp,
  input  logic                 out_en,
  output logic [NCH-1:0]       pwm_main,
  output logic [NCH-1:0]       pwm_comp,
  output logic                 upd
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [NCH-1:0]   ref_w;

  pwm3_timebase #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_tb (
    .clk(clk), .rst(rst), .period_in(period_in),
    .cnt_o(cnt), .wrap_o(wrap), .upd_o(upd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm3_refgen #(.CNT_W(CNT_W), .DEF_CMP(DEF_CMP)) u_ref (
      .clk(clk), .rst(rst), .cnt_i(cnt), .wrap_i(wrap),
      .cmp_in(cmp_in[i*CNT_W +: CNT_W]),
      .mode_i(chan_mode_e'(mode_in[2*i +: 2])),
      .ref_o(ref_w[i])
    );
    pwm3_deadtime #(.DT_CYC(DT_CYC)) u_dt (
      .clk(clk), .rst(rst), .ref_i(ref_w[i]),
      .en_m(en_main[i]), .en_c(en_comp[i]), .moe(out_en),
      .out_m(pwm_main[i]), .out_c(pwm_comp[i])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pwm_main == '0 && pwm_comp == '0 && !upd)) else $error("outputs active after reset"); // R11
endmodule

// File: tb/pwm3_gen_test.sv
module pwm3_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int P = 40;
  localparam int DT = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] period_in = 16'd40;
  logic [47:0] cmp_in = {3{16'd100}};
  logic [5:0]  mode_in = 6'b0;
  logic [2:0]  en_main = 3'b0;
  logic [2:0]  en_comp = 3'b0;
  logic        out_en = 1'b0;
  logic [2:0]  pwm_main, pwm_comp;
  logic        upd;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int hm[3];
  int hc[3];
  int ovl;

  pwm3_gen uut (
    .clk(clk), .rst(rst), .period_in(period_in), .cmp_in(cmp_in),
    .mode_in(mode_in), .en_main(en_main), .en_comp(en_comp), .out_en(out_en),
    .pwm_main(pwm_main), .pwm_comp(pwm_comp), .upd(upd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
        summary();
        $finish;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cmp(input int a, input int b, input int c);
    cmp_in = {16'(c), 16'(b), 16'(a)};
  endtask

  task automatic wait_upd();
    for (int g = 0; g < 5000 && !upd; g++) @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk); wait_upd();
    @(negedge clk); wait_upd();
  endtask

  // called at the negedge of an update cycle; ends at the next one
  task automatic measure(input int len);
    ovl = 0;
    for (int k = 0; k < 3; k++) begin hm[k] = 0; hc[k] = 0; end
    for (int i = 0; i < len; i++) begin
      for (int k = 0; k < 3; k++) begin
        hm[k] += int'(pwm_main[k]);
        hc[k] += int'(pwm_comp[k]);
        if (pwm_main[k] && pwm_comp[k]) ovl++;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R11 main after reset", int'(pwm_main), 0);
    chk("R11 comp after reset", int'(pwm_comp), 0);
    chk("R11 upd after reset", int'(upd), 0);
  endtask

  task automatic t_period();
    int gap;
    gap = 0;
    rst = 1'b0;
    while (!upd && gap < 5000) begin @(negedge clk); gap++; end
    chk("R1 default period to first upd", gap, 2250);
    @(negedge clk); gap = 1;
    while (!upd && gap < 5000) begin @(negedge clk); gap++; end
    chk("R1 gap with loaded period", gap, P);
    repeat (10) @(negedge clk);
    period_in = 16'd30;
    gap = 10;
    while (!upd && gap < 5000) begin @(negedge clk); gap++; end
    chk("R2 period kept after mid-period write", gap, P);
    period_in = 16'd40;
    @(negedge clk); gap = 1;
    while (!upd && gap < 5000) begin @(negedge clk); gap++; end
    chk("R2 new period after wrap", gap, 30);
    settle();
  endtask

  task automatic t_main_only();
    out_en = 1'b1; en_main = 3'b111; en_comp = 3'b000; mode_in = 6'b0;
    set_cmp(10, 20, 25);
    settle();
    measure(P);
    chk("R4 ch0 main width", hm[0], 10);
    chk("R4 ch1 main width", hm[1], 20);
    chk("R4 ch2 main width", hm[2], 25);
    chk("R9 comp disabled stays low", hc[0] + hc[1] + hc[2], 0);
  endtask

  task automatic t_comp_only();
    en_main = 3'b000; en_comp = 3'b111;
    settle();
    measure(P);
    chk("R8 ch0 comp width no dead time", hc[0], 30);
    chk("R8 ch2 comp width no dead time", hc[2], 15);
    chk("R9 main disabled stays low", hm[0] + hm[1] + hm[2], 0);
  endtask

  task automatic t_deadtime();
    en_main = 3'b111; en_comp = 3'b111;
    set_cmp(20, 25, 30);
    settle();
    measure(P);
    chk("R7 ch0 main width", hm[0], 20 - DT);
    chk("R7 ch1 main width", hm[1], 25 - DT);
    chk("R7 ch2 main width", hm[2], 30 - DT);
    chk("R7 ch0 comp width", hc[0], P - 20 - DT);
    chk("R7 ch1 comp width", hc[1], P - 25 - DT);
    chk("R7 ch2 comp swallowed by dead time", hc[2], 0);
    chk("R7 no overlap", ovl, 0);
  endtask

  task automatic t_cmp_preload();
    int bad;
    en_main = 3'b001; en_comp = 3'b000;
    set_cmp(20, 20, 20);
    settle();
    repeat (25) @(negedge clk);
    set_cmp(35, 20, 20);
    bad = 0;
    while (!upd) begin bad += int'(pwm_main[0]); @(negedge clk); end
    chk("R3 mid-period compare write ignored", bad, 0);
    measure(P);
    chk("R3 compare applied after wrap", hm[0], 35);
    repeat (P - 1) @(negedge clk);
    set_cmp(30, 20, 20);
    @(negedge clk);
    chk("R3 last-cycle write lands on wrap (upd)", int'(upd), 1);
    measure(P);
    chk("R3 last-cycle compare governs next period", hm[0], 30);
  endtask

  task automatic t_force_frozen();
    en_main = 3'b111; en_comp = 3'b111;
    mode_in = {2'b00, 2'b10, 2'b01};
    repeat (DT + 5) @(negedge clk);
    chk("R5 force high main", int'(pwm_main[0]), 1);
    chk("R5 force high comp", int'(pwm_comp[0]), 0);
    chk("R5 force low main", int'(pwm_main[1]), 0);
    chk("R5 force low comp", int'(pwm_comp[1]), 1);
    mode_in = {2'b00, 2'b11, 2'b11};
    repeat (3 * P) @(negedge clk);
    chk("R6 frozen high main", int'(pwm_main[0]), 1);
    chk("R6 frozen low comp", int'(pwm_comp[1]), 1);
    chk("R6 frozen low main", int'(pwm_main[1]), 0);
  endtask

  task automatic t_master_off();
    out_en = 1'b0;
    @(negedge clk);
    chk("R10 main low one clock after master off", int'(pwm_main), 0);
    chk("R10 comp low one clock after master off", int'(pwm_comp), 0);
    repeat (P) @(negedge clk);
    chk("R10 outputs stay low", int'(pwm_main | pwm_comp), 0);
    out_en = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_period();
    t_main_only();
    t_comp_only();
    t_deadtime();
    t_cmp_preload();
    t_force_frozen();
    t_master_off();
    summary();
    $finish;
  end
endmodule